// File: doc/BRIEF.md
# Interrupt Register Bank Controller

This block keeps the pointer and the enable policy for a stack of hardware register banks that hold CPU context across interrupts. Software sees one 16-bit control word. Its top two bits select a bank-use mode, bit 13 gates the overflow exception, and the low nibble reports the bank that the next save will use. Bits 12:4 always read as zero.

For each accepted interrupt the block decides from the mode, the interrupt's source class and, in the masked mode, a per-level mask bit whether a bank save takes place. A save sends out a one-cycle save strobe with the bank index and moves the pointer up. A restore command moves the pointer down and sends a restore strobe. If a save is needed and every bank is in use, the block raises an overflow exception, provided that exception is enabled. A restore with no bank in use raises an error pulse. The bank storage and the CPU pipeline are outside this block.

The core is a five-state machine. ST_IDLE means no event in the current cycle. ST_SAVE, ST_RESTORE, ST_OVF and ST_UNDER each last one cycle and each drives one output pulse. Every state is re-decided from the inputs at each clock edge, so the named transitions are: any state to ST_SAVE (bank save granted), to ST_OVF (save needed, no bank free, exception enabled), to ST_RESTORE (restore with pointer above zero), to ST_UNDER (restore with pointer at zero), and to ST_IDLE (no event).

Top module: `irb_top`

## Requirements
- R1: After reset, reg_rdata reads 16'h0000 and all four output pulses (save_stb, restore_stb, ovf_exc, restore_err) are low.
- R2: reg_rdata bits 15:14 return the last written mode and bit 13 the last written overflow enable. Bits 12:4 always read 0. A write never changes bits 3:0, which hold the bank pointer.
- R3: In mode 2'b00 no accepted interrupt produces save_stb or ovf_exc, whatever level_bank_mask holds.
- R4: irq_class encodes 2'b00 as a level interrupt, 2'b01 as NMI and 2'b10 as user break. In mode 2'b01 every level interrupt uses a bank, and an NMI or user break never does in any mode.
- R5: If an interrupt accepted at edge N uses a bank, save_stb is high for exactly the cycle after edge N. In that cycle bank_idx equals the pointer before the save, and the pointer reads one higher.
- R6: In mode 2'b11 a level interrupt uses a bank only if bit irq_level of level_bank_mask is 1.
- R7: Mode 2'b10 is stored and read back as written, and it grants no bank use, the same as mode 2'b00.
- R8: A restore_req at edge N with the pointer above 0 lowers the pointer by one. restore_stb is then high in the next cycle, with bank_idx equal to the new pointer.
- R9: A restore_req with the pointer at 0 gives a one-cycle restore_err pulse and no restore_stb, and the pointer stays at 0.
- R10: If a bank save is needed while the pointer equals NBANKS, there is no save and no increment. ovf_exc pulses for one cycle only if bit 13 is 1.
- R11: When irq_accept and restore_req are high in the same cycle, the restore request is ignored.
- R12: At most one of save_stb, restore_stb, ovf_exc and restore_err is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 16 | Write data; only bits 15:13 are stored |
| reg_rdata | output | 16 | Control word read value |
| irq_accept | input | 1 | One-cycle pulse: an interrupt was accepted |
| irq_class | input | 2 | Source class: 00 level, 01 NMI, 10 user break |
| irq_level | input | 4 | Level of the accepted interrupt |
| level_bank_mask | input | 16 | Per-level bank-use mask for mode 11 |
| restore_req | input | 1 | One-cycle pulse: restore from bank |
| save_stb | output | 1 | Bank save strobe |
| restore_stb | output | 1 | Bank restore strobe |
| bank_idx | output | 4 | Bank index for the current strobe |
| ovf_exc | output | 1 | Bank overflow exception pulse |
| restore_err | output | 1 | Restore with no bank in use |

## Verification
The assertions assume that irq_accept and restore_req are single-cycle requests and that irq_class never carries 2'b11. They also assume that irq_level and level_bank_mask are stable in any cycle where irq_accept is high. The bench drives every request for exactly one cycle, using only the three defined class codes. It sets each write, mask and level at the falling edge before the edge that samples them, and returns all request lines to idle between operations.

// File: rtl/irb_pkg.sv
package irb_pkg;

    typedef enum logic [1:0] {
        CLS_LEVEL = 2'b00,
        CLS_NMI   = 2'b01,
        CLS_UBRK  = 2'b10,
        CLS_RSVD  = 2'b11
    } irq_cls_e;

    typedef enum logic [1:0] {
        BM_OFF    = 2'b00,
        BM_ALL    = 2'b01,
        BM_RSVD   = 2'b10,
        BM_MASKED = 2'b11
    } bank_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_SAVE    = 3'd1,
        ST_RESTORE = 3'd2,
        ST_OVF     = 3'd3,
        ST_UNDER   = 3'd4
    } seq_state_e;

    localparam int CTRL_W    = 16;
    localparam int MODE_HI   = 15;
    localparam int MODE_LO   = 14;
    localparam int OVEN_BIT  = 13;

endpackage

// File: rtl/irb_cfg_reg.sv
module irb_cfg_reg
    import irb_pkg::*;
#(
    parameter int BN_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [CTRL_W-1:0] wdata,
    input  logic [BN_W-1:0]   bn,
    output bank_mode_e        mode,
    output logic              ovf_en,
    output logic [CTRL_W-1:0] rdata
);
    localparam int RSVD_W = CTRL_W - 3 - BN_W;

    bank_mode_e mode_q;
    logic       oven_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= BM_OFF;
            oven_q <= 1'b0;
        end else if (wr) begin
            mode_q <= bank_mode_e'(wdata[MODE_HI:MODE_LO]);
            oven_q <= wdata[OVEN_BIT];
        end
    end

    assign mode   = mode_q;
    assign ovf_en = oven_q;
    assign rdata  = {mode_q, oven_q, {RSVD_W{1'b0}}, bn};

endmodule

// File: rtl/irb_policy.sv
module irb_policy
    import irb_pkg::*;
#(
    parameter int LVL_W = 4
) (
    input  bank_mode_e               mode,
    input  logic [1:0]               cls,
    input  logic [LVL_W-1:0]         level,
    input  logic [(1<<LVL_W)-1:0]    mask,
    output logic                     use_bank
);
    localparam int NLVL = 1 << LVL_W;

    logic [NLVL-1:0] lvl_hit;

    genvar g;
    generate
        for (g = 0; g < NLVL; g++) begin : g_lvl
            assign lvl_hit[g] = mask[g] && (level == LVL_W'(g));
        end
    endgenerate

    logic is_level;
    assign is_level = (cls == CLS_LEVEL);

    always_comb begin
        unique case (mode)
            BM_OFF:    use_bank = 1'b0;
            BM_ALL:    use_bank = is_level;
            BM_RSVD:   use_bank = 1'b0;
            BM_MASKED: use_bank = is_level && (|lvl_hit);
            default:   use_bank = 1'b0;
        endcase
    end

endmodule

// File: rtl/irb_seq.sv
module irb_seq
    import irb_pkg::*;
#(
    parameter int NBANKS = 15,
    parameter int BN_W   = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            accept,
    input  logic            use_bank,
    input  logic            restore,
    input  logic            ovf_en,
    output logic [BN_W-1:0] bn,
    output logic [BN_W-1:0] idx,
    output logic            save_stb,
    output logic            restore_stb,
    output logic            ovf_exc,
    output logic            restore_err
);
    localparam logic [BN_W-1:0] LAST = BN_W'(NBANKS);
    localparam logic [BN_W-1:0] ONE  = BN_W'(1);

    seq_state_e      state_q, state_d;
    logic [BN_W-1:0] bn_q, bn_d;
    logic [BN_W-1:0] idx_q, idx_d;

    always_comb begin
        state_d = ST_IDLE;
        bn_d    = bn_q;
        idx_d   = idx_q;
        if (accept) begin
            if (use_bank) begin
                if (bn_q == LAST) begin
                    state_d = ovf_en ? ST_OVF : ST_IDLE;
                end else begin
                    state_d = ST_SAVE;
                    idx_d   = bn_q;
                    bn_d    = bn_q + ONE;
                end
            end
        end else if (restore) begin
            if (bn_q == '0) begin
                state_d = ST_UNDER;
            end else begin
                state_d = ST_RESTORE;
                bn_d    = bn_q - ONE;
                idx_d   = bn_q - ONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bn_q    <= '0;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            bn_q    <= bn_d;
            idx_q   <= idx_d;
        end
    end

    always_comb begin
        save_stb    = 1'b0;
        restore_stb = 1'b0;
        ovf_exc     = 1'b0;
        restore_err = 1'b0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_SAVE:    save_stb    = 1'b1;
            ST_RESTORE: restore_stb = 1'b1;
            ST_OVF:     ovf_exc     = 1'b1;
            ST_UNDER:   restore_err = 1'b1;
            default:    ;
        endcase
    end

    assign bn  = bn_q;
    assign idx = idx_q;

endmodule

// File: rtl/irb_top.sv
module irb_top
    import irb_pkg::*;
#(
    parameter int NBANKS = 15,
    parameter int BN_W   = 4,
    parameter int LVL_W  = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_wr,
    input  logic [15:0]            reg_wdata,
    output logic [15:0]            reg_rdata,
    input  logic                   irq_accept,
    input  logic [1:0]             irq_class,
    input  logic [LVL_W-1:0]       irq_level,
    input  logic [(1<<LVL_W)-1:0]  level_bank_mask,
    input  logic                   restore_req,
    output logic                   save_stb,
    output logic                   restore_stb,
    output logic [BN_W-1:0]        bank_idx,
    output logic                   ovf_exc,
    output logic                   restore_err
);
    bank_mode_e      mode;
    logic            ovf_en;
    logic            use_bank;
    logic [BN_W-1:0] bn;

    irb_cfg_reg #(.BN_W(BN_W)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (reg_wr),
        .wdata (reg_wdata),
        .bn    (bn),
        .mode  (mode),
        .ovf_en(ovf_en),
        .rdata (reg_rdata)
    );

    irb_policy #(.LVL_W(LVL_W)) u_pol (
        .mode    (mode),
        .cls     (irq_class),
        .level   (irq_level),
        .mask    (level_bank_mask),
        .use_bank(use_bank)
    );

    irb_seq #(.NBANKS(NBANKS), .BN_W(BN_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (irq_accept),
        .use_bank   (use_bank),
        .restore    (restore_req),
        .ovf_en     (ovf_en),
        .bn         (bn),
        .idx        (bank_idx),
        .save_stb   (save_stb),
        .restore_stb(restore_stb),
        .ovf_exc    (ovf_exc),
        .restore_err(restore_err)
    );

endmodule

// File: rtl/irb_top_chk.sv
module irb_top_chk #(
    parameter int NBANKS = 15,
    parameter int BN_W   = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic [15:0]     reg_rdata,
    input logic            irq_accept,
    input logic [1:0]      irq_class,
    input logic            save_stb,
    input logic            restore_stb,
    input logic [BN_W-1:0] bank_idx,
    input logic            ovf_exc,
    input logic            restore_err
);
    localparam logic [BN_W-1:0] LAST = BN_W'(NBANKS);

    // R12
    a_r12_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({save_stb, restore_stb, ovf_exc, restore_err}));

    // R5
    a_r5_save_advances: assert property (@(posedge clk) disable iff (!rst_n)
        save_stb |-> (reg_rdata[BN_W-1:0] == BN_W'(bank_idx + BN_W'(1))));

    a_r5_ptr_moves_only_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[BN_W-1:0] != $past(reg_rdata[BN_W-1:0])) |-> (save_stb || restore_stb));

    // R8
    a_r8_restore_index: assert property (@(posedge clk) disable iff (!rst_n)
        restore_stb |-> (reg_rdata[BN_W-1:0] == bank_idx));

    // R9
    a_r9_err_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        restore_err |-> (reg_rdata[BN_W-1:0] == '0));

    // R10
    a_r10_ovf_gated: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_exc |-> ((reg_rdata[BN_W-1:0] == LAST) && $past(reg_rdata[13])));

    // R2
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[12:4] == 9'd0);

    // R3
    a_r3_mode_off: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_accept && reg_rdata[15:14] == 2'b00) |=> (!save_stb && !ovf_exc));

    // R4
    a_r4_nmi_ubrk_skip: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_accept && irq_class != 2'b00) |=> (!save_stb && !ovf_exc));

endmodule

bind irb_top irb_top_chk #(.NBANKS(NBANKS), .BN_W(BN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_rdata  (reg_rdata),
    .irq_accept (irq_accept),
    .irq_class  (irq_class),
    .save_stb   (save_stb),
    .restore_stb(restore_stb),
    .bank_idx   (bank_idx),
    .ovf_exc    (ovf_exc),
    .restore_err(restore_err)
);

// File: tb/irb_top_tb.sv
`timescale 1ns/1ps
module irb_top_tb;
    localparam int NB = 15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq_accept = 1'b0;
    logic [1:0]  irq_class = 2'b00;
    logic [3:0]  irq_level = '0;
    logic [15:0] level_bank_mask = '0;
    logic        restore_req = 1'b0;
    logic        save_stb, restore_stb, ovf_exc, restore_err;
    logic [3:0]  bank_idx;

    always #2 clk = ~clk;

    irb_top u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_accept(irq_accept), .irq_class(irq_class),
        .irq_level(irq_level), .level_bank_mask(level_bank_mask),
        .restore_req(restore_req), .save_stb(save_stb), .restore_stb(restore_stb),
        .bank_idx(bank_idx), .ovf_exc(ovf_exc), .restore_err(restore_err)
    );

    // kinds: 0 none, 1 save, 2 restore, 3 overflow, 4 error
    typedef struct {
        int       kind;
        logic [3:0] idx;
        string    req;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int         bn_m = 0;
    logic [1:0] mode_m = 2'b00;
    logic       oven_m = 1'b0;

    task automatic push(int kind, int idx, string req);
        exp_t e;
        e.kind = kind; e.idx = 4'(idx); e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic idle_inputs();
        reg_wr = 0; irq_accept = 0; restore_req = 0;
    endtask

    task automatic idle(string req);
        @(negedge clk);
        idle_inputs();
        push(0, 0, req);
    endtask

    task automatic write_ctrl(logic [15:0] v, string req);
        @(negedge clk);
        idle_inputs();
        reg_wr = 1; reg_wdata = v;
        mode_m = v[15:14]; oven_m = v[13];
        push(0, 0, req);
    endtask

    task automatic accept(logic [1:0] cls, int lvl, logic [15:0] mask, bit also_restore, string req);
        bit usebank;
        @(negedge clk);
        idle_inputs();
        irq_accept = 1; irq_class = cls; irq_level = 4'(lvl);
        level_bank_mask = mask; restore_req = also_restore;
        case (mode_m)
            2'b01:   usebank = (cls == 2'b00);
            2'b11:   usebank = (cls == 2'b00) && mask[lvl];
            default: usebank = 0;
        endcase
        if (!usebank) push(0, 0, req);
        else if (bn_m == NB) push(oven_m ? 3 : 0, 0, req);
        else begin
            push(1, bn_m, req);
            bn_m++;
        end
    endtask

    task automatic restore(string req);
        @(negedge clk);
        idle_inputs();
        restore_req = 1;
        if (bn_m == 0) push(4, 0, req);
        else begin
            bn_m--;
            push(2, bn_m, req);
        end
    endtask

    task automatic check_reg(string req);
        logic [15:0] exp_v;
        idle(req);
        exp_v = {mode_m, oven_m, 9'd0, 4'(bn_m)};
        checks++;
        if (reg_rdata !== exp_v) begin
            fails++;
            $display("FAIL %s: reg_rdata actual=%h expected=%h", req, reg_rdata, exp_v);
        end
    endtask

    // monitor: compare outputs just after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n) begin
                exp_t e;
                int got;
                if (exp_q.size() > 0) e = exp_q.pop_front();
                else begin e.kind = 0; e.idx = 0; e.req = "R12"; end
                got = 0;
                if (save_stb) got = 1;
                if (restore_stb) got = 2;
                if (ovf_exc) got = 3;
                if (restore_err) got = 4;
                checks++;
                if ((int'(save_stb) + int'(restore_stb) + int'(ovf_exc) + int'(restore_err)) > 1) begin
                    fails++;
                    $display("FAIL R12: several pulses s=%b r=%b o=%b e=%b expected at most one",
                             save_stb, restore_stb, ovf_exc, restore_err);
                end else if (got != e.kind || ((got == 1 || got == 2) && bank_idx !== e.idx)) begin
                    fails++;
                    $display("FAIL %s: event actual=%0d idx=%0d expected=%0d idx=%0d",
                             e.req, got, bank_idx, e.kind, e.idx);
                end
            end
        end
    end

    initial begin
        #400000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: run hung actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        check_reg("R1");
        // R3 mode 00 ignores mask
        accept(2'b00, 3, 16'hFFFF, 0, "R3");
        accept(2'b00, 0, 16'hFFFF, 0, "R3");
        // R2 field layout, pointer not writable
        write_ctrl(16'hFFFF, "R2");
        check_reg("R2");
        write_ctrl(16'h0000, "R2");
        check_reg("R2");
        // R4 and R5 mode 01
        write_ctrl(16'h4000, "R4");
        accept(2'b00, 5, 16'h0000, 0, "R5");
        accept(2'b01, 5, 16'hFFFF, 0, "R4");
        accept(2'b10, 5, 16'hFFFF, 0, "R4");
        accept(2'b00, 9, 16'h0000, 0, "R5");
        check_reg("R5");
        // R6 mode 11 per-level mask
        write_ctrl(16'hC000, "R6");
        accept(2'b00, 0, 16'h0005, 0, "R6");
        accept(2'b00, 1, 16'h0005, 0, "R6");
        accept(2'b00, 2, 16'h0005, 0, "R6");
        accept(2'b01, 2, 16'hFFFF, 0, "R4");
        accept(2'b00, 15, 16'h8000, 0, "R6");
        check_reg("R6");
        // R7 reserved mode
        write_ctrl(16'h8000, "R7");
        check_reg("R7");
        accept(2'b00, 4, 16'hFFFF, 0, "R7");
        check_reg("R7");
        // R8 restore down to zero, R9 underflow
        for (int i = 0; i < 5; i++) restore("R8");
        check_reg("R8");
        restore("R9");
        restore("R9");
        check_reg("R9");
        // R10 fill all banks, overflow disabled then enabled
        write_ctrl(16'h4000, "R10");
        for (int i = 0; i < NB; i++) accept(2'b00, i, 16'h0000, 0, "R5");
        accept(2'b00, 1, 16'h0000, 0, "R10");
        check_reg("R10");
        write_ctrl(16'h6000, "R10");
        accept(2'b00, 1, 16'h0000, 0, "R10");
        accept(2'b00, 2, 16'h0000, 0, "R10");
        check_reg("R10");
        // R11 accept and restore together
        restore("R8");
        accept(2'b00, 3, 16'h0000, 1, "R11");
        check_reg("R11");
        accept(2'b01, 3, 16'h0000, 1, "R11");
        check_reg("R11");
        idle("R12");
        idle("R12");
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule